// File: doc/BRIEF.md
# UART Oversampling Rate Generator

This block produces the timing strobes that a UART transmitter and receiver run on. From a fast system clock, or from a slower external serial clock pin, it derives a single-cycle oversampling strobe at sixteen times the line bit rate, plus a bit strobe that marks every sixteenth oversampling strobe. Both strobes are enables in the system clock domain. No second clock is ever driven.

The rate comes from a 10-bit rate word and a 2-bit source select, both held in a register outside this block. The source select chooses the internal or the external clock, and chooses whether that source goes through the prescaler and divisor chain or skips it. In every mode a fixed divide-by-two stage follows, so the fastest line rate is the source rate over 32. The external pin is synchronised and edge-detected, so each of its rising edges counts as one source event.

A change to the source select or to the rate word restarts every counter, and the strobe pattern then starts again from a clean phase. The block has no data stream. All of its pins are plain control and strobe signals with no handshake, and the strobes cannot be held back by the units that consume them.

Top module: `baud_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `bit_tick` are low.
- R2: `os_tick` is high for exactly one clock cycle at a time and is never high in two consecutive cycles.
- R3: With `clk_src` = 2'b00 (internal clock, no divider), `os_tick` repeats every 2 clock cycles, and the rate word has no effect.
- R4: With `clk_src` = 2'b01 (internal clock with divider), `os_tick` repeats every 2·P·N cycles. N is `rate_cfg[7:0]`, and P is set by `rate_cfg[9:8]`: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 64.
- R5: A divisor field of 0 acts as 256.
- R6: With `clk_src` = 2'b10, `os_tick` repeats once every 2 rising edges of `ext_clk`. With `clk_src` = 2'b11, it repeats once every 2·P·N rising edges of `ext_clk`.
- R7: Each rising edge of `ext_clk` counts exactly once, however long the pin stays high.
- R8: When `clk_src` or `rate_cfg` changes, every counter restarts. Counting the edge that samples the new value as edge 0, the first `os_tick` follows clock edge 2·P·N, where P·N = 1 when the divider is bypassed. No tick of any other length appears before it.
- R9: `bit_tick` is high together with the 16th `os_tick` after a restart, and with every 16th `os_tick` after that. It is never high without `os_tick`.
- R10: The slowest internal setting, P = 64 and N = 255, gives an `os_tick` period of 32640 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ext_clk | input | 1 | External serial clock pin, asynchronous |
| clk_src | input | 2 | Source select: bit 1 = external, bit 0 = through the divider |
| rate_cfg | input | 10 | Rate word: [7:0] divisor, [9:8] prescaler code |
| os_tick | output | 1 | One-cycle oversampling strobe (16x bit rate) |
| bit_tick | output | 1 | One-cycle bit strobe, on every 16th `os_tick` |

## Verification
Both strobes are registered. For internal sources, the first `os_tick` after a configuration change appears in the sample taken 2·P·N+1 falling edges after the write, and the first `bit_tick` appears in the sample taken 32·P·N+1 falling edges after it. The bench writes each configuration on a falling edge and counts falling-edge samples from that point, so it checks those exact positions and not a range. For external sources, the synchroniser latency sets an unknown starting phase, so the bench checks only the spacing between consecutive ticks, which depends only on the spacing of the pin's edges.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Source select encoding: bit 1 picks external pin, bit 0 routes through divider
  typedef enum logic [1:0] {
    SRC_INT_RAW = 2'b00,
    SRC_INT_DIV = 2'b01,
    SRC_EXT_RAW = 2'b10,
    SRC_EXT_DIV = 2'b11
  } src_sel_e;

  function automatic logic src_is_ext(input src_sel_e s);
    return s[1];
  endfunction

  function automatic logic src_uses_div(input src_sel_e s);
    return s[0];
  endfunction
endpackage

// File: rtl/baud_src_event.sv
module baud_src_event #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic use_ext,
  output logic evt_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      prev_q <= sync_q[MSB];
    end
  end

  // Internal source: one event every cycle; external: one per synced rising edge
  assign evt_o = use_ext ? (sync_q[MSB] & ~prev_q) : 1'b1;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W     = 2,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);
  localparam int CNT_W = STEP_LOG2 * ((1 << SEL_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // Terminal count is 4**sel - 1: the low sel*STEP_LOG2 bits set
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      term[i] = (i < int'(sel) * STEP_LOG2);
    end
  end

  assign tick_o = evt_i & (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt_i,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;

  // divisor - 1 wraps to all ones for zero, giving 2**DIV_W counts
  assign term   = divisor - 1'b1;
  assign tick_o = evt_i & (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_os_stage.sv
module baud_os_stage #(
  parameter int OS_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stage_tick,
  output logic os_tick,
  output logic bit_tick
);
  localparam int BC_W = $clog2(OS_RATIO);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(OS_RATIO - 1);

  logic            half_q;
  logic [BC_W-1:0] bc_q;
  logic            os_next;

  // Fixed divide by two ahead of the oversample strobe
  assign os_next = stage_tick & half_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      half_q   <= 1'b0;
      bc_q     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= os_next;
      bit_tick <= os_next & (bc_q == BC_LAST);
      if (stage_tick) half_q <= ~half_q;
      if (os_next)    bc_q   <= (bc_q == BC_LAST) ? '0 : bc_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PSEL_W      = 2,
  parameter int PSTEP_LOG2  = 2,
  parameter int OS_RATIO    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ext_clk,
  input  logic [1:0]              clk_src,
  input  logic [DIV_W+PSEL_W-1:0] rate_cfg,
  output logic                    os_tick,
  output logic                    bit_tick
);
  localparam int CFG_W = 2 + DIV_W + PSEL_W;

  src_sel_e          src;
  logic [CFG_W-1:0]  cfg_all;
  logic [CFG_W-1:0]  cfg_q;
  logic              cfg_chg;
  logic              src_evt;
  logic              pre_evt;
  logic              pre_tick;
  logic              div_tick;
  logic              stage_tick;

  assign src     = src_sel_e'(clk_src);
  assign cfg_all = {clk_src, rate_cfg};
  assign cfg_chg = (cfg_all != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_all;
  end

  baud_src_event #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .use_ext (src_is_ext(src)),
    .evt_o   (src_evt)
  );

  assign pre_evt = src_evt & src_uses_div(src);

  baud_prescaler #(.SEL_W(PSEL_W), .STEP_LOG2(PSTEP_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_chg),
    .evt_i  (pre_evt),
    .sel    (rate_cfg[DIV_W +: PSEL_W]),
    .tick_o (pre_tick)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_chg),
    .evt_i   (pre_tick),
    .divisor (rate_cfg[DIV_W-1:0]),
    .tick_o  (div_tick)
  );

  assign stage_tick = src_uses_div(src) ? div_tick : src_evt;

  baud_os_stage #(.OS_RATIO(OS_RATIO)) u_os (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cfg_chg),
    .stage_tick (stage_tick),
    .os_tick    (os_tick),
    .bit_tick   (bit_tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int OS_RATIO = 16,
  parameter int CFG_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg,
  input logic             os_tick,
  input logic             bit_tick
);
  localparam int OC_W = $clog2(OS_RATIO);
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OS_RATIO - 1);

  logic [CFG_W-1:0] prev_cfg;
  logic [OC_W-1:0]  osc;

  // Count of oversample strobes seen since the last restart, modulo OS_RATIO
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cfg <= '0;
      osc      <= '0;
    end else begin
      prev_cfg <= cfg;
      if (cfg != prev_cfg) osc <= '0;
      else if (os_tick)    osc <= (osc == OC_LAST) ? '0 : osc + 1'b1;
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);

  p_bit_on_os_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_bit_sixteenth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == prev_cfg) |-> (bit_tick == (os_tick && osc == OC_LAST)));

  p_quiet_after_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != prev_cfg) |=> !os_tick);
endmodule

bind baud_gen baud_gen_chk #(.OS_RATIO(OS_RATIO), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg      (cfg_all),
  .os_tick  (os_tick),
  .bit_tick (bit_tick)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic [1:0] clk_src = 2'b00;
  logic [9:0] rate_cfg = '0;
  logic       os_tick;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;
  int ext_half = 0;
  int ext_cnt = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  baud_gen i_baud_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .clk_src  (clk_src),
    .rate_cfg (rate_cfg),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

  // External clock model: toggles every ext_half cycles, idle low when 0
  initial begin
    forever begin
      @(negedge clk);
      if (ext_half == 0) begin
        ext_clk = 1'b0;
        ext_cnt = 0;
      end else begin
        ext_cnt++;
        if (ext_cnt >= ext_half) begin
          ext_cnt = 0;
          ext_clk = ~ext_clk;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Fields: src(2) presc(2) div(8) ext_half(8) first(17) period(17) bitfirst(17)
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'd5,   8'd0,  17'd3,     17'd2,     17'd33},   // R3
    {2'd1, 2'd0, 8'd3,   8'd0,  17'd7,     17'd6,     17'd97},   // R4
    {2'd1, 2'd1, 8'd2,   8'd0,  17'd17,    17'd16,    17'd257},  // R4
    {2'd1, 2'd2, 8'd1,   8'd0,  17'd33,    17'd32,    17'd513},  // R4
    {2'd1, 2'd3, 8'd1,   8'd0,  17'd129,   17'd128,   17'd2049}, // R4
    {2'd1, 2'd0, 8'd0,   8'd0,  17'd513,   17'd512,   17'd8193}, // R5
    {2'd2, 2'd0, 8'd7,   8'd3,  17'd0,     17'd12,    17'd0},    // R6
    {2'd3, 2'd1, 8'd3,   8'd2,  17'd0,     17'd96,    17'd0},    // R6
    {2'd3, 2'd0, 8'd1,   8'd20, 17'd0,     17'd80,    17'd0},    // R7
    {2'd1, 2'd3, 8'd255, 8'd0,  17'd32641, 17'd32640, 17'd0}     // R10
  };

  initial begin
    int n, t1, t2, tb, prev_os;
    // R1: reset state
    clk_src  = 2'b01;
    rate_cfg = 10'h001;
    repeat (6) begin
      @(negedge clk);
      check(os_tick == 1'b0 && bit_tick == 1'b0, "R1", {os_tick, bit_tick}, 0);
    end
    clk_src  = 2'b00;
    rate_cfg = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int exp_first, exp_per, exp_bit;
      exp_first = int'(VEC[v][50:34]);
      exp_per   = int'(VEC[v][33:17]);
      exp_bit   = int'(VEC[v][16:0]);
      clk_src   = VEC[v][70:69];
      rate_cfg  = VEC[v][68:59];
      ext_half  = int'(VEC[v][58:51]);
      t1 = 0; t2 = 0; tb = 0; prev_os = 0; n = 0;
      while (n < 70000 && (t2 == 0 || (exp_bit != 0 && tb == 0))) begin
        @(negedge clk);
        n++;
        if (os_tick && prev_os != 0)
          check(1'b0, "R2", n, 0);
        prev_os = os_tick;
        if (os_tick) begin
          if (t1 == 0) t1 = n;
          else if (t2 == 0) t2 = n;
        end
        if (bit_tick && tb == 0) tb = n;
      end
      if (exp_first != 0) check(t1 == exp_first, "R8 first tick", t1, exp_first);
      check(t2 - t1 == exp_per, "R3/R4/R5/R6/R7/R10 period", t2 - t1, exp_per);
      if (exp_bit != 0) check(tb == exp_bit, "R9 first bit tick", tb, exp_bit);
    end

    // R8: restart in the middle of a long period gives no truncated tick
    ext_half = 0;
    clk_src  = 2'b01;
    rate_cfg = {2'd0, 8'd100};
    repeat (150) @(negedge clk);
    rate_cfg = {2'd0, 8'd4};
    t1 = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (os_tick && t1 == 0) t1 = k;
    end
    check(t1 == 9, "R8 mid-period restart", t1, 9);

    // R3: rate word ignored in bypass mode (first tick after restart still at 3)
    clk_src  = 2'b00;
    rate_cfg = {2'd3, 8'd200};
    t1 = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (os_tick && t1 == 0) t1 = k;
    end
    check(t1 == 3, "R3 bypass ignores rate word", t1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule